// File: doc/BRIEF.md
# Receive Frame Disposition Controller

This block sits between the receive byte path of an Ethernet MAC and its receive DMA engine. It decides what happens to each incoming frame. An external address filter gives its verdict once the destination address is complete. An external frame filter gives a verdict that can change at any byte. From these two verdicts the block either drops the frame without trace, streams it to memory and then writes its status, or aborts it part-way by commanding the DMA engine to rewind the current descriptor.

The opening bytes of a frame are held in a small on-block buffer, 32 by default. No memory write happens until that many bytes have arrived and both verdicts are still good, or until a shorter frame ends with both verdicts good. After that, the buffer drains one byte per cycle in arrival order while later bytes queue behind it. When the frame filter turns against a frame that is already streaming, the block pulses a restart command and a buffer-recycle indication. No status is written, and the data and status buffers are used again for the next frame.

Top module: `rx_frame_disposition`

## Requirements
- R1: A frame whose address verdict (addr_vld_i high with addr_ok_i low on a byte) is negative produces no dma_we_o, no status_we_o and no dma_restart_o.
- R2: A frame whose frame verdict (frame_ok_i sampled with each byte) is low on any of bytes 1 to HOLD_BYTES, with the address verdict good, produces no dma_we_o, no status_we_o and no dma_restart_o.
- R3: No dma_we_o is raised for a frame until HOLD_BYTES bytes of it have been accepted or its end-of-frame byte has been accepted.
- R4: Every byte written through dma_we_o/dma_data_o appears in arrival order, with the held bytes first and later bytes behind them, and dma_we_o is high for at most one byte per cycle.
- R5: A frame verdict that goes low on byte HOLD_BYTES+1 or later pulses dma_restart_o and buf_recycle_o for one cycle, the cycle after that byte. No dma_we_o is raised in that cycle or afterwards for that frame, and no status_we_o is raised for it.
- R6: A frame that keeps both verdicts good through its end-of-frame byte has all of its bytes written, and status_we_o then pulses once, in the cycle right after its last write.
- R7: A frame shorter than HOLD_BYTES bytes, down to a single byte, that ends with both verdicts good is written in full and its status is written.
- R8: A frame whose address verdict has not arrived by byte HOLD_BYTES, or by its end-of-frame byte, is discarded with no output activity.
- R9: dma_restart_o and status_we_o are single-cycle pulses and at most one of them occurs per frame.
- R10: After reset, and after each end-of-frame byte has been dealt with, the block is idle. All outputs are low, bytes without rx_sof_i are ignored, and the next frame is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | A received byte is present this cycle |
| rx_data_i | input | 8 | Received byte |
| rx_sof_i | input | 1 | Byte is the first of a frame |
| rx_eof_i | input | 1 | Byte is the last of a frame |
| addr_vld_i | input | 1 | Address verdict accompanies this byte |
| addr_ok_i | input | 1 | Address verdict: 1 passes, 0 fails |
| frame_ok_i | input | 1 | Current frame verdict, sampled with each byte |
| dma_we_o | output | 1 | Write dma_data_o to the receive data buffer |
| dma_data_o | output | 8 | Byte to be written |
| dma_restart_o | output | 1 | Rewind current data descriptor to its start |
| status_we_o | output | 1 | Write the frame status |
| buf_recycle_o | output | 1 | Current data and status buffers are reused |

## Verification
The hardest cases to reach are at the hold boundary. A frame verdict that fails exactly on byte HOLD_BYTES must give a silent discard. The same failure one byte later must give a rewind with some bytes already streamed. The stimulus builds frames with a chosen failure byte index and places frames on both sides of the boundary. Sparse byte timing lets the buffer drain while it refills, and a sequence of abort then passing frame shows that buffer and state recover. A behavioural queue model runs in parallel and gives the expected write, restart and status outputs for every cycle.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_STREAM,
    ST_DRAIN,
    ST_DROP
  } disp_state_e;
endpackage

// File: rtl/rxd_hold_buf.sv
module rxd_hold_buf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= ptr_inc(wr_q);
      if (pop_i)  rd_q <= ptr_inc(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/rxd_len_count.sv
module rxd_len_count #(
  parameter int unsigned LIMIT = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load1_i,
  input  logic                         inc_i,
  output logic [$clog2(LIMIT+1)-1:0]   cnt_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_o <= '0;
    else if (load1_i)                     cnt_o <= CW'(1);
    else if (inc_i && cnt_o != CW'(LIMIT)) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter int unsigned HOLD_BYTES = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              byte_v_i,
  input  logic                              sof_i,
  input  logic                              eof_i,
  input  logic                              addr_vld_i,
  input  logic                              addr_ok_i,
  input  logic                              frame_ok_i,
  input  logic                              buf_empty_i,
  input  logic [$clog2(HOLD_BYTES+1)-1:0]   cnt_i,
  output logic                              push_o,
  output logic                              pop_o,
  output logic                              flush_o,
  output logic                              cnt_load1_o,
  output logic                              cnt_inc_o,
  output logic                              abort_o,
  output logic                              status_o
);
  localparam int unsigned CW = $clog2(HOLD_BYTES + 1);

  disp_state_e st_q, st_d;
  logic        seen_q, seen_d;
  logic        take_hold, first_byte, bad;
  logic [CW:0] nbytes;

  always_comb begin
    st_d        = st_q;
    seen_d      = seen_q;
    push_o      = 1'b0;
    pop_o       = 1'b0;
    flush_o     = 1'b0;
    cnt_load1_o = 1'b0;
    cnt_inc_o   = 1'b0;
    abort_o     = 1'b0;
    status_o    = 1'b0;
    first_byte  = (st_q == ST_IDLE);
    take_hold   = byte_v_i && ((st_q == ST_IDLE && sof_i) || st_q == ST_HOLD);
    nbytes      = first_byte ? (CW+1)'(1) : {1'b0, cnt_i} + 1'b1;
    bad         = (addr_vld_i && !addr_ok_i) || !frame_ok_i;

    if (take_hold) begin
      seen_d = (first_byte ? 1'b0 : seen_q) | addr_vld_i;
      if (bad) begin
        flush_o = 1'b1;
        st_d    = eof_i ? ST_IDLE : ST_DROP;
      end else if (eof_i) begin
        if (seen_d) begin
          push_o = 1'b1;
          st_d   = ST_DRAIN;
        end else begin
          flush_o = 1'b1;
          st_d    = ST_IDLE;
        end
      end else if (int'(nbytes) == HOLD_BYTES) begin
        // hold full: stream only with a known, good address verdict
        if (seen_d) begin
          push_o = 1'b1;
          st_d   = ST_STREAM;
        end else begin
          flush_o = 1'b1;
          st_d    = ST_DROP;
        end
      end else begin
        push_o      = 1'b1;
        cnt_load1_o = first_byte;
        cnt_inc_o   = !first_byte;
        st_d        = ST_HOLD;
      end
    end else begin
      unique case (st_q)
        ST_STREAM: begin
          if (byte_v_i && !frame_ok_i) begin
            abort_o = 1'b1;
            flush_o = 1'b1;
            st_d    = eof_i ? ST_IDLE : ST_DROP;
          end else begin
            pop_o = !buf_empty_i;
            if (byte_v_i) begin
              push_o = 1'b1;
              if (eof_i) st_d = ST_DRAIN;
            end
          end
        end
        ST_DRAIN: begin
          if (!buf_empty_i) pop_o = 1'b1;
          else begin
            status_o = 1'b1;
            st_d     = ST_IDLE;
          end
        end
        ST_DROP: if (byte_v_i && eof_i) st_d = ST_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
    end
  end
endmodule

// File: rtl/rx_frame_disposition.sv
module rx_frame_disposition #(
  parameter int unsigned HOLD_BYTES = 32,
  parameter int unsigned DW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_sof_i,
  input  logic          rx_eof_i,
  input  logic          addr_vld_i,
  input  logic          addr_ok_i,
  input  logic          frame_ok_i,
  output logic          dma_we_o,
  output logic [DW-1:0] dma_data_o,
  output logic          dma_restart_o,
  output logic          status_we_o,
  output logic          buf_recycle_o
);
  localparam int unsigned CW = $clog2(HOLD_BYTES + 1);

  logic          push, pop, flush, load1, inc, abort, stat, empty;
  logic [CW-1:0] cnt;
  logic [DW-1:0] head;

  rxd_ctrl #(.HOLD_BYTES(HOLD_BYTES)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_v_i    (rx_valid_i),
    .sof_i       (rx_sof_i),
    .eof_i       (rx_eof_i),
    .addr_vld_i  (addr_vld_i),
    .addr_ok_i   (addr_ok_i),
    .frame_ok_i  (frame_ok_i),
    .buf_empty_i (empty),
    .cnt_i       (cnt),
    .push_o      (push),
    .pop_o       (pop),
    .flush_o     (flush),
    .cnt_load1_o (load1),
    .cnt_inc_o   (inc),
    .abort_o     (abort),
    .status_o    (stat)
  );

  rxd_len_count #(.LIMIT(HOLD_BYTES)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load1_i (load1),
    .inc_i   (inc),
    .cnt_o   (cnt)
  );

  rxd_hold_buf #(.DEPTH(HOLD_BYTES), .DW(DW)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (rx_data_i),
    .rdata_o (head),
    .empty_o (empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dma_we_o      <= 1'b0;
      dma_data_o    <= '0;
      dma_restart_o <= 1'b0;
      status_we_o   <= 1'b0;
      buf_recycle_o <= 1'b0;
    end else begin
      dma_we_o      <= pop;
      if (pop) dma_data_o <= head;
      dma_restart_o <= abort;
      status_we_o   <= stat;
      buf_recycle_o <= abort;
    end
  end
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker #(
  parameter int unsigned HOLD_BYTES = 32
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_valid_i,
  input logic rx_sof_i,
  input logic rx_eof_i,
  input logic dma_we_o,
  input logic dma_restart_o,
  input logic status_we_o,
  input logic buf_recycle_o
);
  int unsigned seen_q;
  logic        ended_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 0;
      ended_q <= 1'b0;
    end else if (rx_valid_i && rx_sof_i) begin
      seen_q  <= 1;
      ended_q <= rx_eof_i;
    end else if (rx_valid_i) begin
      if (seen_q < HOLD_BYTES) seen_q <= seen_q + 1;
      if (rx_eof_i) ended_q <= 1'b1;
    end
  end

  a_r3_hold_before_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_we_o |-> (seen_q >= HOLD_BYTES || ended_q));
  a_r5_abort_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_restart_o |-> (!dma_we_o && !status_we_o));
  a_r6_status_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_we_o |-> ($past(dma_we_o) && !dma_we_o));
  a_r9_restart_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_restart_o |=> !dma_restart_o);
  a_r9_status_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_we_o |=> !status_we_o);
  a_r9_recycle_not_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_recycle_o |-> !status_we_o);
endmodule

bind rx_frame_disposition rxd_checker #(.HOLD_BYTES(HOLD_BYTES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_valid_i    (rx_valid_i),
  .rx_sof_i      (rx_sof_i),
  .rx_eof_i      (rx_eof_i),
  .dma_we_o      (dma_we_o),
  .dma_restart_o (dma_restart_o),
  .status_we_o   (status_we_o),
  .buf_recycle_o (buf_recycle_o)
);

// File: tb/sim_rx_frame_disposition.sv
module sim_rx_frame_disposition;
  localparam int HOLD = 32;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       rx_valid_i = 0, rx_sof_i = 0, rx_eof_i = 0;
  logic [7:0] rx_data_i = '0;
  logic       addr_vld_i = 0, addr_ok_i = 0, frame_ok_i = 1;
  logic       dma_we_o, dma_restart_o, status_we_o, buf_recycle_o;
  logic [7:0] dma_data_o;

  rx_frame_disposition #(.HOLD_BYTES(HOLD)) u0 (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle 1 hold 2 stream 3 drain 4 drop
  int         m_st = 0, m_cnt = 0;
  bit         m_seen = 0;
  byte        m_q[$];
  bit         e_we = 0, e_rst = 0, e_st = 0;
  logic [7:0] e_data = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_seen = 0; m_q.delete();
      e_we = 0; e_rst = 0; e_st = 0;
    end else begin
      e_we = 0; e_rst = 0; e_st = 0;
      if (rx_valid_i && ((m_st == 0 && rx_sof_i) || m_st == 1)) begin
        m_cnt  = (m_st == 0) ? 1 : m_cnt + 1;
        m_seen = ((m_st == 0) ? 1'b0 : m_seen) | addr_vld_i;
        if ((addr_vld_i && !addr_ok_i) || !frame_ok_i) begin
          m_q.delete(); m_st = rx_eof_i ? 0 : 4;
        end else if (rx_eof_i) begin
          if (m_seen) begin m_q.push_back(rx_data_i); m_st = 3; end
          else begin m_q.delete(); m_st = 0; end
        end else if (m_cnt == HOLD) begin
          if (m_seen) begin m_q.push_back(rx_data_i); m_st = 2; end
          else begin m_q.delete(); m_st = 4; end
        end else begin
          m_q.push_back(rx_data_i); m_st = 1;
        end
      end else if (m_st == 2) begin
        if (rx_valid_i && !frame_ok_i) begin
          e_rst = 1; m_q.delete(); m_st = rx_eof_i ? 0 : 4;
        end else begin
          if (m_q.size() > 0) begin e_we = 1; e_data = m_q.pop_front(); end
          if (rx_valid_i) begin
            m_q.push_back(rx_data_i);
            if (rx_eof_i) m_st = 3;
          end
        end
      end else if (m_st == 3) begin
        if (m_q.size() > 0) begin e_we = 1; e_data = m_q.pop_front(); end
        else begin e_st = 1; m_st = 0; end
      end else if (m_st == 4) begin
        if (rx_valid_i && rx_eof_i) m_st = 0;
      end
    end
  end

  // per-frame tallies
  int  t_wr = 0, t_st = 0, t_rs = 0, t_first = -1, bytes_sent = 0;
  byte t_data[$];
  byte sent[$];

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(dma_we_o == e_we, "R4 dma_we_o", dma_we_o, e_we);
      if (e_we) check(dma_data_o == e_data, "R4 dma_data_o", dma_data_o, e_data);
      check(dma_restart_o == e_rst, "R5 dma_restart_o", dma_restart_o, e_rst);
      check(buf_recycle_o == e_rst, "R5 buf_recycle_o", buf_recycle_o, e_rst);
      check(status_we_o == e_st, "R6 status_we_o", status_we_o, e_st);
      if (dma_we_o) begin
        if (t_wr == 0) t_first = bytes_sent;
        t_wr++; t_data.push_back(dma_data_o);
      end
      if (status_we_o) t_st++;
      if (dma_restart_o) t_rs++;
    end
  end

  task automatic idle_in();
    rx_valid_i = 0; rx_sof_i = 0; rx_eof_i = 0; addr_vld_i = 0; frame_ok_i = 1;
  endtask

  task automatic send_frame(input int len, input int addr_at, input bit a_ok,
                            input int fail_at, input bit sparse, input int seed);
    t_wr = 0; t_st = 0; t_rs = 0; t_first = -1; bytes_sent = 0;
    t_data.delete(); sent.delete();
    for (int i = 1; i <= len; i++) begin
      if (sparse) repeat (i % 3) begin @(negedge clk_i); idle_in(); end
      @(negedge clk_i);
      rx_valid_i = 1;
      rx_data_i  = 8'((i * 29 + seed) & 8'hff);
      rx_sof_i   = (i == 1);
      rx_eof_i   = (i == len);
      addr_vld_i = (i == addr_at);
      addr_ok_i  = a_ok;
      frame_ok_i = (fail_at == 0) || (i < fail_at);
      sent.push_back(rx_data_i);
      bytes_sent++;
    end
    @(negedge clk_i); idle_in();
    while (m_st != 0) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic expect_nothing(input string tag);
    check(t_wr == 0, {tag, " writes"}, t_wr, 0);
    check(t_st == 0, {tag, " status"}, t_st, 0);
    check(t_rs == 0, {tag, " restart"}, t_rs, 0);
  endtask

  task automatic expect_pass(input string tag, input int len);
    int mism = 0;
    check(t_wr == len, {tag, " write count"}, t_wr, len);
    check(t_st == 1, {tag, " status once"}, t_st, 1);
    check(t_rs == 0, {tag, " no restart"}, t_rs, 0);
    for (int k = 0; k < t_data.size() && k < sent.size(); k++)
      if (t_data[k] != sent[k]) mism++;
    check(mism == 0, "R4 byte order", mism, 0);
    check(t_first >= ((len < HOLD) ? len : HOLD), "R3 first write after hold",
          t_first, (len < HOLD) ? len : HOLD);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(!dma_we_o && !dma_restart_o && !status_we_o && !buf_recycle_o,
          "R10 reset outputs", dma_we_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    send_frame(60, 6, 1, 0, 0, 1);   expect_pass("R6 full frame", 60);
    send_frame(50, 6, 0, 0, 0, 2);   expect_nothing("R1 address fail");
    send_frame(50, 6, 1, 10, 0, 3);  expect_nothing("R2 fail byte 10");
    send_frame(50, 6, 1, HOLD, 0, 4); expect_nothing("R2 fail byte 32");

    send_frame(50, 6, 1, HOLD + 1, 0, 5);
    check(t_rs == 1, "R5 restart on byte 33", t_rs, 1);
    check(t_st == 0, "R9 no status after abort", t_st, 0);

    send_frame(45, 6, 1, 0, 0, 6);   expect_pass("R10 frame after abort", 45);
    send_frame(20, 6, 1, 0, 0, 7);   expect_pass("R7 short frame", 20);
    send_frame(HOLD, 6, 1, 0, 0, 8); expect_pass("R7 exact hold length", HOLD);
    send_frame(1, 1, 1, 0, 0, 9);    expect_pass("R7 one byte", 1);
    send_frame(40, 0, 1, 0, 0, 10);  expect_nothing("R8 no address verdict");
    send_frame(10, 0, 1, 0, 0, 11);  expect_nothing("R8 short no verdict");
    send_frame(70, 6, 1, 0, 1, 12);  expect_pass("R3 sparse bytes", 70);

    send_frame(80, 6, 1, 55, 1, 13);
    check(t_rs == 1 && t_st == 0, "R9 sparse abort", t_rs, 1);

    // bytes with no start marker while idle
    t_wr = 0; t_st = 0; t_rs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      rx_valid_i = 1; rx_data_i = 8'(i); addr_vld_i = (i == 5); addr_ok_i = 1;
      rx_eof_i = (i == 39);
    end
    @(negedge clk_i); idle_in();
    repeat (40) @(negedge clk_i);
    expect_nothing("R10 stray bytes");

    send_frame(33, 6, 1, 0, 0, 14);  expect_pass("R6 hold plus one", 33);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule